// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds two pending flags for each processor, up to four processors. One flag is an inter-processor interrupt, driven out as a level-3 request. The other is an interval-timer interrupt, driven out as a level-2 request. A timer tick input posts the timer interrupt to every processor that is present. Software posts and retires inter-processor interrupts, and retires timer interrupts, through one of two paths. The first is a packed control word that carries all three masks at once. The second is a set of dedicated registers, each of which takes a single processor mask.

Reads are combinational from a register select. A read of the control word returns both sets of pending flags together with the identifier of the processor that issues the read. Malformed writes raise a one-cycle error pulse. Redundant operations raise a one-cycle warning pulse: a request to a processor that is already pending, or a clear to a processor that has nothing pending.

Top module: `ipi_tmr_ctl`

## Requirements
- R1: After reset all pending flags are zero, `ipi_irq`, `tmr_irq`, `err` and `warn` are low, and a control-word read returns only `req_id` in bits 1:0.
- R2: A write with `wr_sel`=0 (control word) sets the inter-processor flag of processor n when bit 12+n is one. The output reflects this from the clock edge that takes the write.
- R3: In a control-word write, bit 8+n clears the inter-processor flag of processor n. If the same write both requests and clears one processor, the clear wins.
- R4: In a control-word write, bit 4+n clears the timer flag of processor n. Flags whose mask bit is zero are left unchanged.
- R5: A cycle with `tick` high sets the timer flag of every present processor. A timer clear in the same cycle does not stop the tick from setting the flag.
- R6: A control-word write with bits 15:4 all zero and bit 28 zero pulses `err` for one cycle and changes no flag. A write with only bit 28 set is accepted without `err` and changes no flag.
- R7: `warn` pulses for one cycle after a write that requests an inter-processor interrupt for a processor already pending. It also pulses after a write that clears one for a processor with nothing pending once that write's own requests are applied. Flags then are as they would be without the redundant bit.
- R8: A write with `wr_sel`=3 sets the inter-processor flags selected by bits 3:0. If bits 3:0 are all zero, `err` pulses and nothing changes.
- R9: A write with `wr_sel`=1 clears the inter-processor flags selected by bits 3:0, and a write with `wr_sel`=2 clears the timer flags selected by bits 3:0. A zero mask pulses `err` and changes nothing.
- R10: A read with `rd_sel`=0 returns the inter-processor flags in bits 11:8, the timer flags in bits 7:4 and `req_id` in bits 1:0, with zeros elsewhere.
- R11: A read with `rd_sel`=1 returns the inter-processor flags in bits 3:0, and a read with `rd_sel`=2 returns the timer flags in bits 3:0. A read with `rd_sel`=3 returns zero.
- R12: Mask bits for processors at index `NCPU` or above are ignored by every write and by the tick. They never set a flag or cause a warning, and they read back as zero. Such a mask still counts as non-zero for R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write register: 0 control word, 1 IPI clear, 2 timer clear, 3 IPI request |
| wr_data | input | DW | Write data |
| rd_sel | input | 2 | Read register: 0 control word, 1 IPI pending, 2 timer pending, 3 zero |
| req_id | input | 2 | Identifier of the processor issuing the read |
| rd_data | output | DW | Read data |
| tick | input | 1 | Interval-timer tick |
| ipi_irq | output | NCPU | Level-3 inter-processor interrupt per processor |
| tmr_irq | output | NCPU | Level-2 timer interrupt per processor |
| err | output | 1 | One-cycle pulse after a malformed write |
| warn | output | 1 | One-cycle pulse after a redundant request or clear |

## Verification
The hardest cases to reach from the ports are the ones where two actions land on the same processor in the same cycle. One is a request and a clear inside one control word: there the clear must win and no warning may appear, because the request has just made the flag pending. The other is a timer tick that coincides with a timer clear. The directed sequence builds known flag patterns first. It then issues these coincident writes and checks the flags and pulses on the edge that takes them. The bench instantiates three processors, so a fourth mask bit exercises the ignore rule.

// File: rtl/ipi_tmr_ctl.sv
module ipi_tmr_ctl #(
  parameter int unsigned NCPU = 4,
  parameter int unsigned DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  input  logic [1:0]    req_id,
  output logic [DW-1:0] rd_data,
  input  logic          tick,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] tmr_irq,
  output logic          err,
  output logic          warn
);
  localparam int unsigned MW = 4;
  localparam logic [MW-1:0] PRESENT = MW'((1 << NCPU) - 1);

  logic [MW-1:0] ipi_q, tmr_q, ipi_req, ipi_clr, tmr_clr, ipi_d, tmr_d;
  logic is_ctl, is_iclr, is_tclr, is_ireq, err_d, warn_d;

  assign is_ctl  = wr_en && wr_sel == 2'd0;
  assign is_iclr = wr_en && wr_sel == 2'd1;
  assign is_tclr = wr_en && wr_sel == 2'd2;
  assign is_ireq = wr_en && wr_sel == 2'd3;

  assign ipi_req = PRESENT & (is_ctl ? wr_data[15:12] : is_ireq ? wr_data[3:0] : '0);
  assign ipi_clr = PRESENT & (is_ctl ? wr_data[11:8]  : is_iclr ? wr_data[3:0] : '0);
  assign tmr_clr = PRESENT & (is_ctl ? wr_data[7:4]   : is_tclr ? wr_data[3:0] : '0);

  assign ipi_d = (ipi_q | ipi_req) & ~ipi_clr;
  assign tmr_d = (tmr_q & ~tmr_clr) | (tick ? PRESENT : '0);

  assign err_d  = (is_ctl && wr_data[15:4] == '0 && !wr_data[28])
               || ((is_iclr || is_tclr || is_ireq) && wr_data[3:0] == '0);
  assign warn_d = |(ipi_req & ipi_q) || |(ipi_clr & ~(ipi_q | ipi_req));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipi_q <= '0;
      tmr_q <= '0;
      err   <= 1'b0;
      warn  <= 1'b0;
    end else begin
      ipi_q <= err_d ? ipi_q : ipi_d;
      tmr_q <= err_d ? (tmr_q | (tick ? PRESENT : '0)) : tmr_d;
      err   <= err_d;
      warn  <= warn_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      2'd0: begin
        rd_data[11:8] = ipi_q;
        rd_data[7:4]  = tmr_q;
        rd_data[1:0]  = req_id;
      end
      2'd1: rd_data[3:0] = ipi_q;
      2'd2: rd_data[3:0] = tmr_q;
      default: rd_data = '0;
    endcase
  end

  assign ipi_irq = ipi_q[NCPU-1:0];
  assign tmr_irq = tmr_q[NCPU-1:0];
endmodule

// File: rtl/ipi_tmr_ctl_chk.sv
module ipi_tmr_ctl_chk #(
  parameter int unsigned NCPU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            tick,
  input logic [NCPU-1:0] ipi_irq,
  input logic [NCPU-1:0] tmr_irq,
  input logic            err,
  input logic            warn
);
  p_tick_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (&tmr_irq));

  p_ipi_rise_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((ipi_irq & ~$past(ipi_irq)) == '0));

  p_ipi_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ipi_irq));

  p_tmr_rise_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((tmr_irq & ~$past(tmr_irq)) == '0));

  p_err_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !err);

  p_warn_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !warn);

  p_err_keeps_ipi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(ipi_irq));
endmodule

bind ipi_tmr_ctl ipi_tmr_ctl_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick),
  .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .err(err), .warn(warn)
);

// File: tb/ipi_tmr_ctl_tb.sv
`timescale 1ns/1ps
module ipi_tmr_ctl_tb;
  localparam int NCPU = 3;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0, req_id = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic [NCPU-1:0] ipi_irq, tmr_irq;
  logic err, warn;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipi_tmr_ctl #(.NCPU(NCPU), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .req_id(req_id), .rd_data(rd_data), .tick(tick),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .err(err), .warn(warn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d, logic tk);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d; tick = tk;
    @(posedge clk); #1;
    @(negedge clk);
    wr_en = 0; tick = 0;
  endtask

  task automatic expect_state(string req, logic [2:0] ei, logic [2:0] et, logic ee, logic ew);
    chk(req, 32'(ipi_irq), 32'(ei));
    chk(req, 32'(tmr_irq), 32'(et));
    chk(req, 32'(err), 32'(ee));
    chk(req, 32'(warn), 32'(ew));
  endtask

  task automatic t_reset();
    req_id = 2; rd_sel = 0; #1;
    expect_state("R1", 3'b000, 3'b000, 0, 0);
    chk("R1", rd_data, 32'h2);
  endtask

  task automatic t_misc_request();
    wr(0, 32'h3000, 0);
    @(posedge clk);
    expect_state("R2", 3'b011, 3'b000, 0, 0);
    rd_sel = 1; #1;
    chk("R11", rd_data, 32'h3);
  endtask

  task automatic t_redundant();
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 32'h1000;
    @(posedge clk); #1;
    expect_state("R7", 3'b011, 3'b000, 0, 1);
    @(negedge clk); wr_data = 32'h0400;
    @(posedge clk); #1;
    expect_state("R7", 3'b011, 3'b000, 0, 1);
    @(negedge clk); wr_en = 0;
    @(posedge clk); #1;
    chk("R7", 32'(warn), 0);
  endtask

  task automatic t_misc_clear();
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 32'h0100;
    @(posedge clk); #1;
    expect_state("R3", 3'b010, 3'b000, 0, 0);
    @(negedge clk); wr_data = 32'h1100;
    @(posedge clk); #1;
    expect_state("R3", 3'b010, 3'b000, 0, 0);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_tick();
    @(negedge clk); tick = 1;
    @(posedge clk); #1;
    chk("R5", 32'(tmr_irq), 32'h7);
    @(negedge clk); tick = 0;
    rd_sel = 2; #1;
    chk("R11", rd_data, 32'h7);
    rd_sel = 0; req_id = 1; #1;
    chk("R10", rd_data, 32'h271);
    rd_sel = 3; #1;
    chk("R11", rd_data, 32'h0);
  endtask

  task automatic t_timer_clear();
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 32'h0050;
    @(posedge clk); #1;
    expect_state("R4", 3'b010, 3'b010, 0, 0);
    @(negedge clk); wr_sel = 2; wr_data = 32'h2; tick = 1;
    @(posedge clk); #1;
    expect_state("R5", 3'b010, 3'b111, 0, 0);
    @(negedge clk); wr_en = 0; tick = 0;
  endtask

  task automatic t_errors();
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 32'h0;
    @(posedge clk); #1;
    expect_state("R6", 3'b010, 3'b111, 1, 0);
    @(negedge clk); wr_data = 32'h1000_0000;
    @(posedge clk); #1;
    expect_state("R6", 3'b010, 3'b111, 0, 0);
    @(negedge clk); wr_data = 32'h0000_000F;
    @(posedge clk); #1;
    expect_state("R6", 3'b010, 3'b111, 1, 0);
    @(negedge clk); wr_en = 0;
    @(posedge clk); #1;
    chk("R6", 32'(err), 0);
  endtask

  task automatic t_direct();
    @(negedge clk); wr_en = 1; wr_sel = 3; wr_data = 32'h4;
    @(posedge clk); #1;
    expect_state("R8", 3'b110, 3'b111, 0, 0);
    @(negedge clk); wr_data = 32'hF0;
    @(posedge clk); #1;
    expect_state("R8", 3'b110, 3'b111, 1, 0);
    @(negedge clk); wr_sel = 1; wr_data = 32'h2;
    @(posedge clk); #1;
    expect_state("R9", 3'b100, 3'b111, 0, 0);
    @(negedge clk); wr_sel = 2; wr_data = 32'h0;
    @(posedge clk); #1;
    expect_state("R9", 3'b100, 3'b111, 1, 0);
    @(negedge clk); wr_data = 32'h7;
    @(posedge clk); #1;
    expect_state("R9", 3'b100, 3'b000, 0, 0);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_absent_cpu();
    @(negedge clk); wr_en = 1; wr_sel = 3; wr_data = 32'h8;
    @(posedge clk); #1;
    expect_state("R12", 3'b100, 3'b000, 0, 0);
    @(negedge clk); wr_sel = 0; wr_data = 32'h8000;
    @(posedge clk); #1;
    expect_state("R12", 3'b100, 3'b000, 0, 0);
    @(negedge clk); wr_sel = 1; wr_data = 32'h8;
    @(posedge clk); #1;
    expect_state("R12", 3'b100, 3'b000, 0, 0);
    @(negedge clk); wr_en = 0; tick = 1;
    @(posedge clk); #1;
    @(negedge clk); tick = 0;
    rd_sel = 2; #1;
    chk("R12", rd_data, 32'h7);
    rd_sel = 1; #1;
    chk("R12", rd_data, 32'h4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_misc_request();
    t_redundant();
    t_misc_clear();
    t_tick();
    t_timer_clear();
    t_errors();
    t_direct();
    t_absent_cpu();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule